// File: doc/BRIEF.md
# Watermark-Triggered Burst Write Master

This block sits between a sample producer and a shared memory bus. Incoming 32-bit samples are written into a 64-word internal buffer as they arrive. The block does not touch the bus while the buffer is filling. Once the buffer holds three quarters of its capacity, the block asks the bus arbiter for ownership. When the grant comes back, the block becomes the bus master and streams the buffered words to host memory as one burst, one word per accepted cycle. It then drops its request and returns to collecting.

The upstream side is a valid/ready stream. A sample moves only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` falls only when the buffer is full, so a producer that honours it never loses data. The downstream write channel follows the same rule. A word, together with its address, is taken on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the block holds its word and address unchanged. The request/grant pair is plain level signalling. The host buffer is described by `base_addr` and by `buf_words`, its length in words. The write address steps through that ring and wraps back to the base after the last word.

If the arbiter withdraws the grant in the middle of a burst, the block completes the word it is currently offering and then re-requests the bus. The data it has not sent stays buffered, and the next burst continues at the following address.

Top module: `burst_dma_writer`

## Requirements
- R1: A sample is stored whenever `in_valid` and `in_ready` are high at a clock edge. `in_ready` is low exactly when 64 words are buffered, and no offered sample is dropped.
- R2: From the idle state, `bus_req` rises on the cycle after buffer occupancy is at least 48 words, and it stays low while occupancy is below 48.
- R3: `wr_valid` stays low until the arbiter has granted the bus. A burst starts on the cycle after `bus_gnt` is seen high while requesting.
- R4: A burst carries as many words as were buffered on the grant cycle, in arrival order, and moves one word per cycle where `wr_valid` and `wr_ready` are both high.
- R5: `wr_addr` equals `base_addr` plus 4 times the word offset. The offset advances by one only on an accepted word, and address and data hold while `wr_ready` is low.
- R6: `wr_last` is high together with the final word of a burst and at no other time.
- R7: After the final word is accepted, the block spends exactly one cycle with `bus_req` and `wr_valid` both low, then returns to idle.
- R8: If `bus_gnt` is low when a word is accepted that is not the final word, the block goes back to requesting with `bus_req` high. The remaining words stay buffered, and the next burst continues at the next address.
- R9: The word offset wraps from `buf_words`-1 back to 0, so the address returns to `base_addr`.
- R10: After reset, `bus_req`, `wr_valid` and `wr_last` are low, `in_ready` is high, and `wr_addr` equals `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Buffer can take a sample |
| in_data | input | 32 | Sample value |
| base_addr | input | 32 | Host ring base byte address |
| buf_words | input | 16 | Host ring length in words (at least 1) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| wr_addr | output | 32 | Byte address of the current word |
| wr_data | output | 32 | Current word |
| wr_valid | output | 1 | Word on the write channel is valid |
| wr_last | output | 1 | Final word of the burst |
| wr_ready | input | 1 | Target accepts the word |

## Verification
On every cycle, the assertions check the following: the buffer never overflows, and `wr_valid` only rises after a grant. A stalled word keeps its address and data. `wr_last` never appears without `wr_valid`. The release cycle keeps request and valid low. A request from idle starts only at the watermark, and the ring offset stays inside the buffer length. Other properties need the bench's cycle-accurate reference model and its scenarios: that a burst carries exactly the words buffered at grant, in order; that a preempted burst resumes at the right address; and that the ring wraps to the base. The scenarios use steady grants, random target stalls, random grant withdrawal, and a held-off grant that fills the buffer.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_REL   = 2'd3
  } dma_state_e;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH):0]       fill,
  output logic                         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head = mem[rd_ptr];
  assign fill = cnt;
  assign full = (cnt == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH))); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0)); // R4
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import dma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WM    = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] fill,
  input  logic                   gnt,
  input  logic                   wr_ready,
  output logic                   req,
  output logic                   valid,
  output logic                   last,
  output logic                   accept
);
  localparam int CW = $clog2(DEPTH) + 1;

  dma_state_e    state;
  logic [CW-1:0] remain;

  assign req    = (state == ST_REQ) || (state == ST_BURST);
  assign valid  = (state == ST_BURST);
  assign last   = valid && (remain == CW'(1));
  assign accept = valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fill >= CW'(WM)) state <= ST_REQ;
        ST_REQ: if (gnt) begin
          state  <= ST_BURST;
          remain <= fill;
        end
        ST_BURST: if (accept) begin
          remain <= remain - 1'b1;
          if (last)      state <= ST_REL;
          else if (!gnt) state <= ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_AT_WATERMARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (fill >= CW'(WM))); // R2
  AST_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(gnt)); // R3
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid); // R6
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last && wr_ready) |=> (!req && !valid) ##1 (state == ST_IDLE)); // R7
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] buf_words,
  output logic [AW-1:0] addr
);
  logic [LW-1:0] offset;
  logic [LW:0]   nxt;

  assign nxt = {1'b0, offset} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   offset <= '0;
    else if (adv) offset <= (nxt >= {1'b0, buf_words}) ? '0 : nxt[LW-1:0];
  end

  assign addr = base + (AW'(offset) << 2);

  AST_OFFSET_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_words != '0 && $past(buf_words) == buf_words) |-> (offset < buf_words)); // R9
endmodule

// File: rtl/burst_dma_writer.sv
module burst_dma_writer #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] buf_words,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_valid,
  output logic          wr_last,
  input  logic          wr_ready
);
  localparam int WM = (DEPTH * 3) / 4;
  localparam int CW = $clog2(DEPTH) + 1;

  logic          push, full, accept;
  logic [CW-1:0] fill;

  assign in_ready = !full;
  assign push     = in_valid && in_ready;

  sample_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data),
    .pop(accept), .head(wr_data), .fill(fill), .full(full)
  );

  burst_ctrl #(.DEPTH(DEPTH), .WM(WM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fill(fill), .gnt(bus_gnt), .wr_ready(wr_ready),
    .req(bus_req), .valid(wr_valid), .last(wr_last), .accept(accept)
  );

  addr_gen #(.AW(AW), .LW(LW)) u_addr (
    .clk(clk), .rst_n(rst_n), .adv(accept), .base(base_addr),
    .buf_words(buf_words), .addr(wr_addr)
  );

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && $stable(base_addr)) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5
  AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < CW'(DEPTH)) |-> in_ready); // R1
endmodule

// File: tb/sim_burst_dma_writer.sv
module sim_burst_dma_writer;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int RING = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        bus_gnt = 1'b0;
  logic        wr_ready = 1'b0;
  logic [31:0] base_addr = BASE;
  logic [15:0] buf_words = 16'(RING);
  logic        in_ready, bus_req, wr_valid, wr_last;
  logic [31:0] wr_addr, wr_data;

  always #2.5 clk = ~clk;

  burst_dma_writer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .base_addr(base_addr), .buf_words(buf_words),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 idle, 1 requesting, 2 bursting, 3 release
  logic [31:0] q[$];
  int m_st = 0;
  int m_rem = 0;
  int m_off = 0;
  int releases = 0;
  int preempts = 0;
  int wraps = 0;
  bit model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n || !model_on) begin
      q.delete(); m_st = 0; m_rem = 0; m_off = 0;
    end else begin
      bit push;
      int sz;
      push = in_valid && (q.size() < 64);
      sz = q.size();
      case (m_st)
        0: if (sz >= 48) m_st = 1;
        1: if (bus_gnt) begin m_st = 2; m_rem = sz; end
        2: if (wr_ready) begin
          void'(q.pop_front());
          m_off = (m_off + 1 >= RING) ? 0 : m_off + 1;
          if (m_off == 0) wraps++;
          if (m_rem == 1) begin m_st = 3; releases++; end
          else if (!bus_gnt) begin m_st = 1; preempts++; end
          m_rem--;
        end
        default: m_st = 0;
      endcase
      if (push) q.push_back(in_data);
    end
  end

  // compare outputs against the model in the middle of every cycle
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      logic [31:0] ea;
      ea = BASE + 32'(m_off * 4);
      check(in_ready == (q.size() < 64), "R1 in_ready", 32'(in_ready), 32'(q.size() < 64));
      check(bus_req == (m_st == 1 || m_st == 2), "R2 bus_req", 32'(bus_req), 32'(m_st == 1 || m_st == 2));
      check(wr_valid == (m_st == 2), "R3 wr_valid", 32'(wr_valid), 32'(m_st == 2));
      check(wr_addr == ea, "R5 wr_addr", wr_addr, ea);
      if (m_st == 2) begin
        check(wr_data == q[0], "R4 wr_data", wr_data, q[0]);
        check(wr_last == (m_rem == 1), "R6 wr_last", 32'(wr_last), 32'(m_rem == 1));
      end else begin
        check(!wr_last, "R6 wr_last idle", 32'(wr_last), 32'd0);
      end
      if (m_st == 3) check(!bus_req && !wr_valid, "R7 release quiet",
                           {30'd0, bus_req, wr_valid}, 32'd0);
    end
  end

  // stimulus knobs, applied at the falling edge
  int vprob = 100;
  int rprob = 100;
  int gmode = 0;
  always @(negedge clk) begin
    #0.5;
    in_valid = ($urandom_range(99) < vprob);
    in_data  = $urandom;
    wr_ready = ($urandom_range(99) < rprob);
    case (gmode)
      0: bus_gnt = bus_req;
      1: bus_gnt = bus_req && ($urandom_range(7) != 0);
      default: bus_gnt = 1'b0;
    endcase
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    vprob = 0; gmode = 2;
    run(4);
    @(negedge clk);
    // R10 reset state
    check(!bus_req && !wr_valid && !wr_last, "R10 outputs low",
          {29'd0, bus_req, wr_valid, wr_last}, 32'd0);
    check(in_ready, "R10 in_ready", 32'(in_ready), 32'd1);
    check(wr_addr == BASE, "R10 wr_addr", wr_addr, BASE);
    rst_n = 1'b1; model_on = 1'b1;

    // R2: 47 words must not request
    vprob = 100; gmode = 0; rprob = 100;
    run(47);
    vprob = 0;
    run(5);
    @(negedge clk);
    check(!bus_req, "R2 below watermark", 32'(bus_req), 32'd0);
    vprob = 100;
    run(400);                       // steady bursts, R4 R6 R7 R9
    rprob = 50;  run(1500);         // target stalls, R5
    gmode = 1;   run(2000);         // grant withdrawal, R8
    gmode = 2; rprob = 100; vprob = 100;
    run(120);
    @(negedge clk);
    check(!in_ready && q.size() == 64, "R1 full back-pressure",
          32'(in_ready), 32'd0);
    gmode = 0; run(300);
    vprob = 60; gmode = 1; rprob = 70; run(2000);

    check(releases > 5, "R7 release cycles seen", 32'(releases), 32'd6);
    check(preempts > 0, "R8 preemptions seen", 32'(preempts), 32'd1);
    check(wraps > 0, "R9 ring wraps seen", 32'(wraps), 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule